// File: doc/BRIEF.md
# Digit-Serial Most-Significant-First Dot-Product Engine

This block computes the inner product of a vector of signed weights with a vector of activations. The weights are applied all at once. The activations arrive as signed digits, one digit per lane per cycle, leading digit first. The result leaves the block the same way: one signed digit per cycle, leading digit first. The first result digit follows the first input digit after a fixed lead of two digits.

Each run begins with a start pulse. The pulse captures the weight vector and the requested output precision, which is between two and seven digits. The run ends once that many result digits have been emitted. No cycles are spent on lower-order digits, and later input digits are dropped until the next start pulse.

Each weight is read as a two's-complement fraction w/2^(W_BITS-1). The sum over the lanes is divided by N_LANES, a power of two, so that the result stays inside (-1, 1). Digits use a redundant signed-digit code. Each output digit is chosen by looking at the leading bits of a scaled residual.

Top module: `msdf_dot_engine`

## Requirements
- R1: Digit codes are 2'b10 for +1, 2'b01 for -1 and 2'b00 for 0, with the high bit as the plus flag. The output never carries 2'b11, and an input lane that carries 2'b11 counts as a zero digit.
- R2: A start pulse captures the weight vector and precision for the whole run. Changes on those inputs after the pulse have no effect on that run. An activation digit presented in the same cycle as start is not consumed.
- R3: A run emits exactly P result digits, where P is the latched precision. Precision codes 0 and 1 are treated as 2, and codes 2 to 7 are used as given.
- R4: Result digit j is valid in the cycle after the clock edge that accepts input digit j+2. Every accepted input digit from the third one onward yields exactly one result digit. A cycle without act_valid yields no result digit.
- R5: done is high in exactly the one cycle that carries the last of the P result digits.
- R6: After done, further act_valid digits are ignored and res_valid stays low until the next start pulse.
- R7: The emitted value Σ z_j·2^-j differs from Σ_i (w_i/2^(W_BITS-1))·a_i / N_LANES by at most three quarters of 2^-P. Here a_i is the value formed by the first P+2 digits of lane i.
- R8: While reset is held and after it is released, res_valid, done and res_digit are all zero until a run produces output.
- R9: A start pulse during an active run abandons that run. The new run behaves exactly as it would from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run; captures weights and precision |
| prec | input | 3 | Requested number of result digits |
| weights | input | N_LANES*W_BITS | Packed two's-complement weights, lane 0 in the low bits |
| act_valid | input | 1 | An activation digit vector is present |
| act_digits | input | 2*N_LANES | One signed digit per lane, lane 0 in the low bits |
| res_valid | output | 1 | res_digit carries a result digit |
| res_digit | output | 2 | Result signed digit |
| done | output | 1 | Marks the last result digit of the run |

## Verification
A residual that drifts outside its bound cannot be corrected by later digits. It appears as a reconstructed result more than three quarters of an output unit away from the exact product. The error shows at the latest when the final digit of that run arrives. The digit counter and phase are exposed more directly: a counter that is off by one moves res_valid or done by a cycle, or changes the number of digits in the run. The bench compares both signals against its own model every cycle, so such a fault is caught within the first run that hits it. A weight or precision latch fault shows in the same run, because the bench scrambles those inputs immediately after each start pulse.

// File: rtl/msdf_ipu_pkg.sv
package msdf_ipu_pkg;

    localparam int ONLINE_DELAY = 2;
    localparam int MIN_PREC     = 2;
    localparam int MAX_PREC     = 7;
    localparam int PREC_W       = 3;

    typedef logic [1:0] sd_code_t;

    localparam sd_code_t SD_ZERO = 2'b00;
    localparam sd_code_t SD_POS  = 2'b10;
    localparam sd_code_t SD_NEG  = 2'b01;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_EMIT = 2'd2
    } phase_e;

    typedef struct packed {
        logic accept;
        logic emit;
        logic last;
    } step_ctl_t;

    // Decode a signed digit; the illegal code reads as zero.
    function automatic logic signed [1:0] sd_decode(input sd_code_t c);
        case (c)
            SD_POS:  return 2'sd1;
            SD_NEG:  return -2'sd1;
            default: return 2'sd0;
        endcase
    endfunction

    function automatic sd_code_t sd_encode(input logic signed [1:0] d);
        if (d == 2'sd1)
            return SD_POS;
        else if (d == -2'sd1)
            return SD_NEG;
        else
            return SD_ZERO;
    endfunction

    function automatic logic [PREC_W-1:0] clamp_prec(input logic [PREC_W-1:0] p);
        if (p < PREC_W'(MIN_PREC))
            return PREC_W'(MIN_PREC);
        else
            return p;
    endfunction

endpackage

// File: rtl/ipu_term_sum.sv
module ipu_term_sum
    import msdf_ipu_pkg::*;
#(
    parameter int N_LANES = 4,
    parameter int W_BITS  = 8,
    parameter int SW      = 13
) (
    input  logic [N_LANES*W_BITS-1:0] w_flat,
    input  logic [2*N_LANES-1:0]      digits,
    output logic signed [SW-1:0]      term
);

    logic signed [SW-1:0] part [N_LANES];

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        logic signed [W_BITS-1:0] w_i;
        logic signed [SW-1:0]     w_x;
        logic signed [1:0]        d_i;

        assign w_i = w_flat[i*W_BITS +: W_BITS];
        assign w_x = w_i;
        assign d_i = sd_decode(digits[2*i +: 2]);

        always_comb begin
            if (d_i == 2'sd1)
                part[i] = w_x;
            else if (d_i == -2'sd1)
                part[i] = -w_x;
            else
                part[i] = '0;
        end
    end

    always_comb begin
        term = '0;
        for (int i = 0; i < N_LANES; i++)
            term = term + part[i];
    end

endmodule

// File: rtl/ipu_residual.sv
module ipu_residual
    import msdf_ipu_pkg::*;
#(
    parameter int K  = 9,
    parameter int SW = K + ONLINE_DELAY + 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 step,
    input  logic                 sel_en,
    input  logic signed [SW-1:0] term,
    output sd_code_t             z_code
);

    localparam int SHIFT = K + ONLINE_DELAY - 1;
    localparam int LW    = SW - SHIFT;
    localparam logic signed [SW-1:0] ONE   = SW'(2 ** (K + ONLINE_DELAY));
    localparam logic signed [SW-1:0] BOUND = SW'(3 * (2 ** K));
    localparam logic signed [LW-1:0] L_ONE  = LW'(1);
    localparam logic signed [LW-1:0] L_MONE = -LW'(1);

    logic signed [SW-1:0] resid;
    logic signed [SW-1:0] est;
    logic signed [SW-1:0] nxt;
    logic signed [LW-1:0] lead;
    logic signed [1:0]    zd;

    always_comb begin
        est  = (resid <<< 1) + term;
        lead = est[SW-1:SHIFT];
        zd   = 2'sd0;
        if (sel_en) begin
            if (lead >= L_ONE)
                zd = 2'sd1;
            else if (lead < L_MONE)
                zd = -2'sd1;
        end
        if (zd == 2'sd1)
            nxt = est - ONE;
        else if (zd == -2'sd1)
            nxt = est + ONE;
        else
            nxt = est;
    end

    assign z_code = sd_encode(zd);

    always_ff @(posedge clk) begin
        if (rst || clear)
            resid <= '0;
        else if (step)
            resid <= nxt;
    end

    AST_RESID_BOUND: assert property (@(posedge clk) disable iff (rst)
        (resid <= BOUND) && (resid >= -BOUND)) else $error("residual out of bound"); // R7

endmodule

// File: rtl/ipu_seq_ctrl.sv
module ipu_seq_ctrl
    import msdf_ipu_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              act_valid,
    input  logic [PREC_W-1:0] prec_in,
    output step_ctl_t         ctl
);

    phase_e            phase;
    logic [CW-1:0]     cnt;
    logic [PREC_W-1:0] prec_l;
    logic [CW-1:0]     cnt_inc;
    logic [CW-1:0]     target;

    always_comb begin
        cnt_inc    = cnt + CW'(1);
        target     = CW'(prec_l) + CW'(ONLINE_DELAY);
        ctl.accept = (phase != PH_IDLE) && act_valid && !start;
        ctl.emit   = ctl.accept && (phase == PH_EMIT);
        ctl.last   = ctl.emit && (cnt_inc == target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            prec_l <= PREC_W'(MIN_PREC);
        end else if (start) begin
            phase  <= PH_FILL;
            cnt    <= '0;
            prec_l <= clamp_prec(prec_in);
        end else if (ctl.accept) begin
            cnt <= cnt_inc;
            if (ctl.last)
                phase <= PH_IDLE;
            else if ((phase == PH_FILL) && (cnt_inc == CW'(ONLINE_DELAY)))
                phase <= PH_EMIT;
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (cnt < target)) else $error("digit count past run length"); // R3
    AST_PREC_FLOOR: assert property (@(posedge clk) disable iff (rst)
        prec_l >= PREC_W'(MIN_PREC)) else $error("latched precision below floor"); // R3

endmodule

// File: rtl/msdf_dot_engine.sv
module msdf_dot_engine
    import msdf_ipu_pkg::*;
#(
    parameter int N_LANES = 4,
    parameter int W_BITS  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [2:0]                prec,
    input  logic [N_LANES*W_BITS-1:0] weights,
    input  logic                      act_valid,
    input  logic [2*N_LANES-1:0]      act_digits,
    output logic                      res_valid,
    output logic [1:0]                res_digit,
    output logic                      done
);

    localparam int LOGN = $clog2(N_LANES);
    localparam int K    = LOGN + W_BITS - 1;
    localparam int SW   = K + ONLINE_DELAY + 2;
    localparam int CW   = $clog2(MAX_PREC + ONLINE_DELAY + 1);

    logic [N_LANES*W_BITS-1:0] w_lat;
    logic signed [SW-1:0]      term;
    sd_code_t                  z_code;
    step_ctl_t                 ctl;

    always_ff @(posedge clk) begin
        if (rst)
            w_lat <= '0;
        else if (start)
            w_lat <= weights;
    end

    ipu_seq_ctrl #(.CW(CW)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .act_valid (act_valid),
        .prec_in   (prec),
        .ctl       (ctl)
    );

    ipu_term_sum #(.N_LANES(N_LANES), .W_BITS(W_BITS), .SW(SW)) u_terms (
        .w_flat (w_lat),
        .digits (act_digits),
        .term   (term)
    );

    ipu_residual #(.K(K), .SW(SW)) u_resid (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .step   (ctl.accept),
        .sel_en (ctl.emit),
        .term   (term),
        .z_code (z_code)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_digit <= SD_ZERO;
            done      <= 1'b0;
        end else begin
            res_valid <= ctl.emit;
            res_digit <= ctl.emit ? z_code : SD_ZERO;
            done      <= ctl.last;
        end
    end

    AST_DIGIT_LEGAL: assert property (@(posedge clk) disable iff (rst)
        res_digit != 2'b11) else $error("illegal output digit"); // R1
    AST_IDLE_DIGIT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (res_digit == SD_ZERO)) else $error("digit without valid"); // R1
    AST_VALID_NEEDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(act_valid) && !$past(start))) else $error("output without input"); // R4
    AST_DONE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        done |-> res_valid) else $error("done without digit"); // R5
    AST_HALT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        done |=> !res_valid) else $error("output after done"); // R6

endmodule

// File: tb/sim_msdf_dot_engine.sv
module sim_msdf_dot_engine;

    localparam int N = 4;
    localparam int W = 8;
    localparam int K = 9;

    logic           clk = 1'b0;
    logic           rst;
    logic           start;
    logic [2:0]     prec;
    logic [N*W-1:0] weights;
    logic           act_valid;
    logic [2*N-1:0] act_digits;
    logic           res_valid;
    logic [1:0]     res_digit;
    logic           done;

    int     checks = 0;
    int     errors = 0;
    int     cyc    = 0;
    int     wt [N];
    bit     m_active = 1'b0;
    int     m_k = 0;
    int     m_p = 2;
    longint zint = 0;
    int     nout = 0;

    always #2.5 clk = ~clk;

    msdf_dot_engine #(.N_LANES(N), .W_BITS(W)) u0 (
        .clk(clk), .rst(rst), .start(start), .prec(prec), .weights(weights),
        .act_valid(act_valid), .act_digits(act_digits),
        .res_valid(res_valid), .res_digit(res_digit), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int dval(input logic [1:0] c);
        if (c == 2'b10) return 1;
        if (c == 2'b01) return -1;
        return 0;
    endfunction

    function automatic logic [2*N-1:0] make_digits(input int mode);
        logic [2*N-1:0] d;
        for (int i = 0; i < N; i++) begin
            int r;
            r = $urandom_range(0, 2);
            case (mode)
                1: d[2*i +: 2] = 2'b10;
                2: d[2*i +: 2] = 2'b01;
                3: d[2*i +: 2] = 2'($urandom_range(0, 3));
                default: d[2*i +: 2] = (r == 0) ? 2'b00 : (r == 1) ? 2'b10 : 2'b01;
            endcase
        end
        return d;
    endfunction

    function automatic int cval(input logic [2*N-1:0] d);
        int s = 0;
        for (int i = 0; i < N; i++) s += wt[i] * dval(d[2*i +: 2]);
        return s;
    endfunction

    task automatic step(input logic st, input logic av, input logic [2*N-1:0] dg);
        logic nv = 1'b0;
        logic nd = 1'b0;
        start = st; act_valid = av; act_digits = dg;
        if (st) begin
            m_active = 1'b1; m_k = 0;
        end else if (av && m_active) begin
            m_k++;
            if (m_k > 2) nv = 1'b1;
            if (m_k == m_p + 2) begin nd = 1'b1; m_active = 1'b0; end
        end
        @(negedge clk);
        chk(res_valid === nv, "R4/R6 res_valid timing", longint'(res_valid), longint'(nv));
        chk(done === nd, "R5 done timing", longint'(done), longint'(nd));
        chk(res_digit !== 2'b11, "R1 output code legal", longint'(res_digit), 0);
        if (res_valid) begin
            zint = zint * 2 + dval(res_digit);
            nout++;
        end
    endtask

    task automatic set_weights(input int mode);
        for (int i = 0; i < N; i++) begin
            if (mode == 1) wt[i] = -128;
            else if (mode == 2) wt[i] = 127;
            else wt[i] = $urandom_range(0, 255) - 128;
            weights[i*W +: W] = W'(wt[i]);
        end
    endtask

    task automatic do_run(input int pset, input int mode, input bit gaps, input string tag);
        int peff;
        int k = 0;
        longint e = 0;
        longint diff;
        logic [2*N-1:0] dg;
        peff = (pset < 2) ? 2 : pset;
        set_weights(mode);
        prec = 3'(pset);
        m_p = peff; zint = 0; nout = 0;
        step(1'b1, 1'b1, make_digits(0));
        weights = $urandom;
        prec = 3'($urandom_range(0, 7));
        while (k < peff + 5) begin
            if (gaps && $urandom_range(0, 3) == 0) begin
                step(1'b0, 1'b0, make_digits(0));
            end else begin
                dg = make_digits(mode);
                k++;
                if (k <= peff + 2) e += longint'(cval(dg)) <<< (peff + 2 - k);
                step(1'b0, 1'b1, dg);
            end
        end
        step(1'b0, 1'b0, '0);
        chk(nout == peff, {tag, " R3 digit count"}, nout, peff);
        diff = zint * (longint'(1) <<< (K + 2)) - e;
        if (diff < 0) diff = -diff;
        chk(diff <= 3 * (longint'(1) <<< K), {tag, " R2/R7 value"},
            zint * (longint'(1) <<< (K + 2)), e);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; prec = '0; weights = '0; act_valid = 1'b0; act_digits = '0;
        repeat (3) @(negedge clk);
        chk(res_valid === 1'b0 && done === 1'b0 && res_digit === 2'b00,
            "R8 outputs in reset", longint'({res_valid, done, res_digit}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(res_valid === 1'b0 && done === 1'b0 && res_digit === 2'b00,
            "R8 outputs after reset", longint'({res_valid, done, res_digit}), 0);
        step(1'b0, 1'b1, make_digits(0));

        do_run(7, 1, 1'b0, "extreme negative");
        do_run(2, 1, 1'b0, "extreme negative short");
        do_run(7, 2, 1'b0, "extreme positive");
        do_run(2, 2, 1'b1, "extreme positive short");
        do_run(0, 0, 1'b0, "R3 clamp code 0");
        do_run(1, 0, 1'b1, "R3 clamp code 1");
        for (int p = 2; p <= 7; p++)
            for (int r = 0; r < 6; r++)
                do_run(p, 0, (r % 2) == 1, "random");
        for (int r = 0; r < 6; r++)
            do_run(2 + r, 3, 1'b1, "R1 illegal input read as zero");

        // R9: abandon an active run part way through
        set_weights(0);
        prec = 3'd6; m_p = 6;
        step(1'b1, 1'b0, '0);
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, make_digits(0));
        do_run(5, 0, 1'b1, "R9 restart mid-run");
        do_run(7, 0, 1'b0, "R9 run after restart");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule